// File: doc/BRIEF.md
# Serial Channel Select Register

This block holds the input channel number for an eight-way analog front end ahead of a converter. A host programs it over three wires: a serial clock, a serial data line and a select line. While select is high, each rising edge of the serial clock shifts one data bit into a small command register. When select falls, the captured command is checked. If it is complete and its leading bit requests an update, the channel number changes.

Each successful update also raises a pending flag. The conversion sequencer reads this flag to learn that the new channel applies from the next conversion. The sequencer clears the flag with a one-cycle start pulse. All three serial inputs are brought into the system clock domain through a synchronizer chain. Edges on them are then found by comparing the synchronized value with its previous value.

While select is low, serial clock edges are ignored. The serial clock line can therefore be shared with a readout clock that toggles during data transfer.

Top module: `chsel_reg`

## Requirements
- R1: After reset the channel output is 0 and the pending flag is 0.
- R2: While select is high, each rising edge of the serial clock shifts in the data bit. The first bit of a command is an enable bit, followed by the three channel bits, most significant first. On the select falling edge, a command with enable 1 loads the channel output with its three channel bits.
- R3: Serial clock edges while select is low have no effect: the channel and the pending flag keep their values, and those bits do not count toward the next command.
- R4: A complete command whose enable bit is 0 leaves the channel and the pending flag unchanged. This includes a window in which the data line is held low.
- R5: A window with fewer than four shifted bits is discarded on the select falling edge. This includes a window with no clock edges.
- R6: When more than four bits are shifted in one window, only the last four are used.
- R7: A channel update sets the pending flag. A start pulse clears it. If an update and a start pulse arrive in the same cycle, the update wins.
- R8: The channel output changes only in the cycle that follows a committed update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mux_clk_i | input | 1 | Serial shift clock, asynchronous |
| mux_din_i | input | 1 | Serial command data, asynchronous |
| mux_sel_i | input | 1 | Command window select, high to shift, asynchronous |
| conv_start_i | input | 1 | Sequencer start pulse, clears pending |
| chan_o | output | 3 | Active channel number |
| pending_o | output | 1 | A new channel awaits the next conversion |

## Verification
Directed windows come first. A full four-bit command with enable high must update the channel. The same command with enable low must not. Empty and short windows show whether incomplete commands are dropped, and windows of five to eight bits show whether the last four bits win over the first four. Clock bursts while select is low, with random data, separate a design that gates shifting on select from one that does not. A random mix of window lengths, bit patterns and start pulses then compares the channel and the pending flag against a bench model after every window.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  // Saturating increment used for the shifted-bit counter.
  function automatic int unsigned sat_inc(input int unsigned cur, input int unsigned lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction
endpackage

// File: rtl/chsel_sync.sv
module chsel_sync #(
  parameter int unsigned NSIG   = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSIG-1:0] raw_i,
  output logic [NSIG-1:0] lvl_o,
  output logic [NSIG-1:0] rise_o,
  output logic [NSIG-1:0] fall_o
);
  logic [NSIG-1:0] prev_q;

  for (genvar g = 0; g < NSIG; g++) begin : g_sig
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], raw_i[g]};
    end
    assign lvl_o[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_o;
  end

  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/chsel_shift.sv
module chsel_shift #(
  parameter int unsigned CMD_W = 4,
  localparam int unsigned CNT_W = $clog2(CMD_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_lvl_i,
  input  logic             sel_rise_i,
  input  logic             sclk_rise_i,
  input  logic             din_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic             full_o
);
  import chsel_pkg::*;
  logic [CNT_W-1:0] cnt_q;
  logic             shift_en;

  assign shift_en = sclk_rise_i && sel_lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmd_o <= '0;
    end else if (sel_rise_i) begin
      cnt_q <= '0;
    end else if (shift_en) begin
      cmd_o <= {cmd_o[CMD_W-2:0], din_i};
      cnt_q <= CNT_W'(sat_inc(int'(cnt_q), CMD_W));
    end
  end

  assign full_o = (int'(cnt_q) == CMD_W);

  a_r3_low_select_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_rise_i && !sel_lvl_i && !sel_rise_i) |=> $stable(cnt_q) && $stable(cmd_o));
  a_r5_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= CMD_W);
endmodule

// File: rtl/chsel_commit.sv
module chsel_commit #(
  parameter int unsigned CH_W = 3,
  localparam int unsigned CMD_W = CH_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_fall_i,
  input  logic             full_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             conv_start_i,
  output logic [CH_W-1:0]  chan_o,
  output logic             pending_o
);
  logic commit;

  assign commit = sel_fall_i && full_i && cmd_i[CMD_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_o    <= '0;
      pending_o <= 1'b0;
    end else begin
      if (commit) chan_o <= cmd_i[CH_W-1:0];
      if (commit)            pending_o <= 1'b1;
      else if (conv_start_i) pending_o <= 1'b0;
    end
  end

  a_r8_chan_only_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(chan_o));
  a_r7_commit_sets_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> pending_o);
  a_r7_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_start_i && !commit) |=> !pending_o);
  a_r4_no_commit_without_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_fall_i && !cmd_i[CMD_W-1] && !conv_start_i) |=> $stable(chan_o) && $stable(pending_o));
  a_r5_no_commit_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_fall_i && !full_i && !conv_start_i) |=> $stable(chan_o) && $stable(pending_o));
endmodule

// File: rtl/chsel_reg.sv
module chsel_reg #(
  parameter int unsigned NUM_CH      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CH_W  = $clog2(NUM_CH),
  localparam int unsigned CMD_W = CH_W + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mux_clk_i,
  input  logic            mux_din_i,
  input  logic            mux_sel_i,
  input  logic            conv_start_i,
  output logic [CH_W-1:0] chan_o,
  output logic            pending_o
);
  localparam int unsigned IX_CLK = 0;
  localparam int unsigned IX_DIN = 1;
  localparam int unsigned IX_SEL = 2;

  logic [2:0]       lvl, rise, fall;
  logic [CMD_W-1:0] cmd;
  logic             full;

  chsel_sync #(.NSIG(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  ({mux_sel_i, mux_din_i, mux_clk_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  chsel_shift #(.CMD_W(CMD_W)) shift_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_lvl_i   (lvl[IX_SEL]),
    .sel_rise_i  (rise[IX_SEL]),
    .sclk_rise_i (rise[IX_CLK]),
    .din_i       (lvl[IX_DIN]),
    .cmd_o       (cmd),
    .full_o      (full)
  );

  chsel_commit #(.CH_W(CH_W)) commit_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_fall_i   (fall[IX_SEL]),
    .full_i       (full),
    .cmd_i        (cmd),
    .conv_start_i (conv_start_i),
    .chan_o       (chan_o),
    .pending_o    (pending_o)
  );

  logic unused_edges;
  assign unused_edges = ^{fall[IX_CLK], rise[IX_DIN], fall[IX_DIN]};

  a_r1_reset_values: assert property (@(posedge clk_i)
    !rst_ni |=> (chan_o == '0) && !pending_o);
endmodule

// File: tb/chsel_reg_tb.sv
module chsel_reg_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, din = 1'b0, sel = 1'b0, conv = 1'b0;
  logic [2:0] chan;
  logic       pend;
  int n_chk = 0, n_bad = 0;
  logic [2:0] exp_chan = 3'd0;
  logic       exp_pend = 1'b0;

  always #4 clk = ~clk;

  chsel_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mux_clk_i(sclk), .mux_din_i(din),
    .mux_sel_i(sel), .conv_start_i(conv), .chan_o(chan), .pending_o(pend)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req);
    n_chk++;
    if (chan !== exp_chan || pend !== exp_pend) begin
      n_bad++;
      $display("FAIL %s: chan=%0d pend=%0b expected chan=%0d pend=%0b",
               req, chan, pend, exp_chan, exp_pend);
    end
  endtask

  task automatic pulse_bit(input logic b);
    din = b;  tick(3);
    sclk = 1'b1; tick(3);
    sclk = 1'b0; tick(2);
  endtask

  // Bench model: the last four bits of a window form the command.
  function automatic logic [3:0] last4(input int n, input logic [7:0] bits);
    logic [3:0] s = 4'd0;
    for (int i = 0; i < n; i++) s = {s[2:0], bits[n-1-i]};
    return s;
  endfunction

  function automatic string tag_of(input int n, input logic [3:0] c);
    if (n < 4) return "R5";
    if (!c[3]) return "R4";
    if (n > 4) return "R6";
    return "R2";
  endfunction

  // bits[n-1] is sent first
  task automatic window(input int n, input logic [7:0] bits);
    logic [3:0] c;
    sel = 1'b1; tick(4);
    for (int i = 0; i < n; i++) pulse_bit(bits[n-1-i]);
    sel = 1'b0; din = 1'b0; tick(8);
    c = last4(n, bits);
    if (n >= 4 && c[3]) begin
      exp_chan = c[2:0];
      exp_pend = 1'b1;
    end
    check(tag_of(n, c));
  endtask

  task automatic noise(input int n);
    for (int i = 0; i < n; i++) pulse_bit(1'($urandom));
    tick(4);
    check("R3");
  endtask

  task automatic start_pulse();
    conv = 1'b1; tick(1);
    conv = 1'b0; tick(2);
    exp_pend = 1'b0;
    check("R7");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5eed_0042));
    tick(3);
    check("R1");
    rst_n = 1'b1; tick(2);
    check("R1");

    window(4, 8'b1101);                 // R2: channel 5
    window(4, 8'b0010);                 // R4: enable low
    start_pulse();                      // R7
    window(4, 8'b0000);                 // R4: data held low
    window(0, 8'b0);                    // R5: no clock
    window(3, 8'b111);                  // R5: short
    window(6, 8'b00_1011);              // R6: last four -> ch 3
    window(5, 8'b1_0110);               // R6: last four 0110 -> no update
    noise(6);                           // R3
    window(4, 8'b1111);                 // R2: ch 7
    noise(3);                           // R3: noise before a short window
    window(2, 8'b11);                   // R3/R5: noise bits must not count
    // R7: start pulse coincident with the commit edge -> update wins
    sel = 1'b1; tick(4);
    pulse_bit(1); pulse_bit(0); pulse_bit(1); pulse_bit(0);
    sel = 1'b0; conv = 1'b1;
    tick(1);
    repeat (10) begin
      tick(1);
    end
    conv = 1'b0; tick(2);
    exp_chan = 3'd2; exp_pend = 1'b0;   // start held for many cycles: cleared after
    check("R7");

    for (int k = 0; k < 80; k++) begin
      int unsigned r = $urandom_range(0, 9);
      if (r < 2)       noise(int'($urandom_range(1, 4)));
      else if (r < 3)  start_pulse();
      else             window(int'($urandom_range(0, 8)), 8'($urandom));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule